// File: doc/BRIEF.md
# Handshaked Bit-Serial Word Adder

This block adds two unsigned words of `WIDTH` bits, one bit position at a time, by driving a separate one-bit full-adder through a request/done handshake. A requester places two operand words on the inputs and raises `add_req`. It keeps the request and both operands steady until the block raises `done`. For each position, starting at bit 0, the controller presents the operand bits, a carry-in and a request strobe to the bit-adder. It then waits for the bit-adder's done strobe, stores the returned sum bit at that position, and feeds the returned carry-out back as the next carry-in.

The bit-adder model inside the block computes its sum as the XOR of its three inputs and its carry-out as their majority. It may hold off any request for as long as the `stall` input is high. The controller has only two states, idle and working. One operation is in flight at a time. When the last bit returns, the block shows the assembled sum and the final carry as an unsigned overflow flag, and pulses `done` for one cycle.

Top module: `sba_word_adder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done`, `ovf` and every bit of `sum` read 0.
- R2: When `done` is high, `sum` equals (`opa` + `opb`) modulo 2^WIDTH for the operands held during the operation.
- R3: When `done` is high, `ovf` equals bit WIDTH of the full sum `opa` + `opb`, which is the carry out of the most significant position.
- R4: `done` is high for exactly one cycle per operation.
- R5: With `stall` held low, `done` is high in the cycle that starts 2*WIDTH clock edges after the edge that accepts the request. The accepting edge is the first edge at which `add_req` is high, the block is idle and `done` is low. Each bit position therefore takes two cycles.
- R6: While `stall` is high the bit-adder completes no bit, so `done` cannot rise. After `stall` falls, the operation completes with the result that R2 and R3 give, whatever the pattern of stalls.
- R7: While `add_req` is low, the block starts no operation and `done` stays low. A request that is still high in the cycle where `done` is high does not start a second operation.
- R8: The result is correct for both WIDTH = 4 and WIDTH = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| add_req | input | 1 | Add request, held by the requester until `done` |
| opa | input | WIDTH | First operand, held steady during the operation |
| opb | input | WIDTH | Second operand, held steady during the operation |
| stall | input | 1 | When high, the bit-adder holds off the pending bit request |
| sum | output | WIDTH | Assembled sum word, valid while `done` is high |
| ovf | output | 1 | Unsigned carry out of the top bit, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
With no stall, the result and the completion pulse are due exactly 2*WIDTH edges after the accepting edge. The bench raises the request just after a falling edge and counts falling edges until `done` is seen. The expected count is 2*WIDTH+1, because the accepting edge is the first rising edge after the request is raised. With random or long stalls no fixed latency applies, so the bench samples `sum` and `ovf` at the falling edge where `done` is first high. It then checks at the next falling edge that `done` has dropped. Both widths are checked side by side, each with its own request line, and the expected values come from a plain integer sum of the operands.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [0:0] {
    CTRL_IDLE = 1'b0,
    CTRL_BUSY = 1'b1
  } ctrl_state_t;
endpackage

// File: rtl/sba_bit_unit.sv
// One-bit full adder behind a request/done handshake. It services a pending
// request on any cycle where stall is low, and answers one cycle later.
module sba_bit_unit (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic a_in,
  input  logic b_in,
  input  logic c_in,
  input  logic stall,
  output logic done_q,
  output logic sum_q,
  output logic cout_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      sum_q  <= 1'b0;
      cout_q <= 1'b0;
    end else if (req && !stall && !done_q) begin
      done_q <= 1'b1;
      sum_q  <= a_in ^ b_in ^ c_in;
      cout_q <= (a_in & b_in) | (b_in & c_in) | (c_in & a_in);
    end else begin
      done_q <= 1'b0;
    end
  end

  // R6: a stalled cycle never completes a bit
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !done_q);
  // R4: the per-bit done strobe is a single-cycle pulse
  p_bit_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // a bit completion always answers an outstanding request
  p_done_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(req));
endmodule

// File: rtl/sba_ctrl.sv
// Serial controller: walks the bit positions, drives the bit-adder and
// chains the carry.
module sba_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     add_req,
  input  logic [WIDTH-1:0]         opa,
  input  logic [WIDTH-1:0]         opb,
  input  logic                     word_done,
  input  logic                     bit_done,
  input  logic                     bit_cout,
  output logic [$clog2(WIDTH)-1:0] pos,
  output logic                     bit_req,
  output logic                     a_bit,
  output logic                     b_bit,
  output logic                     c_bit
);
  import sba_pkg::*;
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  ctrl_state_t state;
  logic [CW-1:0] pos_next;

  assign pos_next = pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CTRL_IDLE;
      pos     <= '0;
      bit_req <= 1'b0;
      a_bit   <= 1'b0;
      b_bit   <= 1'b0;
      c_bit   <= 1'b0;
    end else begin
      case (state)
        CTRL_IDLE: begin
          if (add_req && !word_done) begin
            state   <= CTRL_BUSY;
            pos     <= '0;
            bit_req <= 1'b1;
            a_bit   <= opa[0];
            b_bit   <= opb[0];
            c_bit   <= 1'b0;
          end
        end
        default: begin
          if (bit_done) begin
            if (pos == LAST) begin
              bit_req <= 1'b0;
              state   <= CTRL_IDLE;
            end else begin
              a_bit <= opa[pos_next];
              b_bit <= opb[pos_next];
              c_bit <= bit_cout;
              pos   <= pos_next;
            end
          end
        end
      endcase
    end
  end

  // R5: the position counter never passes the last bit
  p_pos_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);
  // R5: a bit request stays up until the bit-adder answers it
  p_req_held_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_req && !bit_done) |=> bit_req);
  // R7: without a request the controller stays idle
  p_no_start_r7: assert property (@(posedge clk) disable iff (rst)
    (state == CTRL_IDLE && !add_req) |=> state == CTRL_IDLE);
  // R7: no restart while the completion pulse is showing
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (state == CTRL_IDLE && word_done) |=> state == CTRL_IDLE);
endmodule

// File: rtl/sba_collect.sv
// Result assembly: stores each returned sum bit at its position and raises
// the completion pulse and overflow flag on the last bit.
module sba_collect #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_done,
  input  logic                     bit_sum,
  input  logic                     bit_cout,
  input  logic [$clog2(WIDTH)-1:0] pos,
  output logic [WIDTH-1:0]         sum,
  output logic                     ovf,
  output logic                     done
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      ovf  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bit_done) begin
        sum[pos] <= bit_sum;
        if (pos == LAST) begin
          done <= 1'b1;
          ovf  <= bit_cout;
        end
      end
    end
  end

  // R4: the word completion is a one-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: completion follows a returned bit
  p_done_after_bit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(bit_done));
endmodule

// File: rtl/sba_word_adder.sv
module sba_word_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_req,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             stall,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             done
);
  localparam int CW = $clog2(WIDTH);

  logic [CW-1:0] pos;
  logic bit_req, a_bit, b_bit, c_bit;
  logic bit_done, bit_sum, bit_cout;

  sba_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .add_req(add_req), .opa(opa), .opb(opb),
    .word_done(done), .bit_done(bit_done), .bit_cout(bit_cout),
    .pos(pos), .bit_req(bit_req), .a_bit(a_bit), .b_bit(b_bit), .c_bit(c_bit)
  );

  sba_bit_unit u_bit (
    .clk(clk), .rst(rst), .req(bit_req), .a_in(a_bit), .b_in(b_bit),
    .c_in(c_bit), .stall(stall), .done_q(bit_done), .sum_q(bit_sum),
    .cout_q(bit_cout)
  );

  sba_collect #(.WIDTH(WIDTH)) u_collect (
    .clk(clk), .rst(rst), .bit_done(bit_done), .bit_sum(bit_sum),
    .bit_cout(bit_cout), .pos(pos), .sum(sum), .ovf(ovf), .done(done)
  );

  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && !ovf && sum == '0));
endmodule

// File: tb/tb_sba_word_adder.sv
module tb_sba_word_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W8 = 8;
  localparam int W4 = 4;
  localparam int NVEC = 10;
  localparam int WATCHDOG = 5000;
  // [17:16] stall mode (0 none, 1 random, 2 burst), [15:8] opa, [7:0] opb
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 8'h00},
    {2'd0, 8'h01, 8'h01},
    {2'd0, 8'hFF, 8'h01},
    {2'd0, 8'h5A, 8'hA5},
    {2'd1, 8'h80, 8'h80},
    {2'd1, 8'h3C, 8'h0F},
    {2'd1, 8'hFF, 8'hFF},
    {2'd2, 8'h7F, 8'h01},
    {2'd2, 8'h99, 8'h77},
    {2'd1, 8'h12, 8'hED}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic req8 = 1'b0, req4 = 1'b0;
  logic [W8-1:0] a8 = '0, b8 = '0;
  logic [W4-1:0] a4 = '0, b4 = '0;
  logic [W8-1:0] sum8;
  logic [W4-1:0] sum4;
  logic ovf8, ovf4, done8, done4;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sba_word_adder #(.WIDTH(W8)) dut (
    .clk(clk), .rst(rst), .add_req(req8), .opa(a8), .opb(b8), .stall(stall),
    .sum(sum8), .ovf(ovf8), .done(done8)
  );

  sba_word_adder #(.WIDTH(W4)) dut_w4 (
    .clk(clk), .rst(rst), .add_req(req4), .opa(a4), .opb(b4), .stall(stall),
    .sum(sum4), .ovf(ovf4), .done(done4)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one operation on both widths; mode selects the stall pattern.
  task automatic run_op(input logic [7:0] x, input logic [7:0] y, input logic [1:0] mode);
    logic [8:0] ref8;
    logic [4:0] ref4;
    int cyc = 0, lat8 = 0, lat4 = 0;
    bit fin8 = 0, fin4 = 0;
    ref8 = {1'b0, x} + {1'b0, y};
    ref4 = {1'b0, x[3:0]} + {1'b0, y[3:0]};
    @(negedge clk);
    a8 = x; b8 = y; a4 = x[3:0]; b4 = y[3:0];
    req8 = 1'b1; req4 = 1'b1;
    stall = (mode == 2'd2);
    while (!(fin8 && fin4)) begin
      @(negedge clk);
      cyc++;
      if (mode == 2'd1) stall = ($urandom_range(0, 2) == 0);
      else if (mode == 2'd2) stall = (cyc % 12) < 9;
      if (!fin8 && done8) begin
        fin8 = 1; lat8 = cyc;
        check(sum8 == ref8[7:0], "R2 R8 sum w8", sum8, ref8[7:0]);
        check(ovf8 == ref8[8], "R3 R8 ovf w8", ovf8, ref8[8]);
        req8 = 1'b0;
        if (mode == 2'd0) check(lat8 == 2*W8+1, "R5 latency w8", lat8, 2*W8+1);
      end
      if (!fin4 && done4) begin
        fin4 = 1; lat4 = cyc;
        check(sum4 == ref4[3:0], "R2 R8 sum w4", sum4, ref4[3:0]);
        check(ovf4 == ref4[4], "R3 R8 ovf w4", ovf4, ref4[4]);
        req4 = 1'b0;
        if (mode == 2'd0) check(lat4 == 2*W4+1, "R5 latency w4", lat4, 2*W4+1);
      end else if (fin4 && cyc == lat4 + 1) begin
        check(!done4, "R4 pulse w4", done4, 0);
      end
      if (cyc > WATCHDOG) begin
        check(1'b0, "watchdog", cyc, WATCHDOG);
        fin8 = 1; fin4 = 1; req8 = 1'b0; req4 = 1'b0;
      end
    end
    stall = 1'b0;
    @(negedge clk);
    check(!done8, "R4 pulse w8", done8, 0);
    check(!done4 || lat4 != cyc, "R4 pulse w4 end", done4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done8 && !ovf8 && sum8 == '0, "R1 reset w8", {ovf8, done8, sum8}, 0);
    check(!done4 && !ovf4 && sum4 == '0, "R1 reset w4", {ovf4, done4, sum4}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done8 && !ovf8 && sum8 == '0, "R1 after reset", {ovf8, done8, sum8}, 0);

    // R7: idle with no request
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done8 || done4) check(1'b0, "R7 idle done", {done8, done4}, 0);
    end
    check(!done8 && !done4, "R7 no request", {done8, done4}, 0);

    for (int v = 0; v < NVEC; v++) run_op(VEC[v][15:8], VEC[v][7:0], VEC[v][17:16]);

    // R6: hold stall high for a long time; no completion may appear
    @(negedge clk);
    a8 = 8'hC3; b8 = 8'h4E; req8 = 1'b1; stall = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (done8) seen = 1;
      end
      check(!seen, "R6 stall blocks", seen, 0);
    end
    stall = 1'b0;
    begin
      int k = 0;
      while (!done8 && k < 200) begin @(negedge clk); k++; end
      check(done8 && sum8 == 8'h11 && ovf8 == 1'b1, "R6 after stall",
            {done8, ovf8, sum8}, {1'b1, 1'b1, 8'h11});
    end
    // R7: request left high through the done cycle; no second start
    @(negedge clk);
    check(!done8, "R4 pulse after stall", done8, 0);
    req8 = 1'b0;
    begin
      bit again = 0;
      for (int i = 0; i < 3*W8; i++) begin
        @(negedge clk);
        if (done8) again = 1;
      end
      check(!again, "R7 no restart", again, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule